// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins and turns activity on them into interrupt requests. Each pin is brought into the clock domain through a two-flop synchroniser. A per-pin sense code then selects falling-edge, rising-edge, both-edge, low-level or high-level detection. Detected events are held in a pending register. Software reads that register and acknowledges events by writing zeros to it.

A request reaches the outputs only when three conditions hold: the pin is pending, it is unmasked, and its priority field is nonzero. Masking uses two write-only registers, one that sets mask bits and one that clears them, so no read-modify-write is ever needed. Every per-pin register is packed with pin 0 at the most significant end.

There are two request outputs. A one-bit control field gates the per-pin request vector. The combined request output is not gated by that field.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: After reset every pin is masked, every priority and sense field reads 0, no pin is pending, the mode bit is 0, and both request outputs are low.
- R2: The register select is decoded as follows. 0 is sense (read/write). 1 is priority (read/write). 2 is pending (read; a write acknowledges). 3 is mask-set (write-only). 4 is mask-clear (write-only). 5 is control; only bit 23 is stored, and every other control bit reads 0. Registers 3, 4, 6 and 7 read as 0.
- R3: Pin k's sense field is the SENSE_W bits starting at bit 32-(k+1)*SENSE_W. Its priority field is the 4 bits starting at bit 28-4k. Its bit in the pending, mask-set and mask-clear registers is bit FLAG_W-1-k. On irq_pin, pin k is bit k.
- R4: Sense code 0 (falling), 1 (rising) and 4 (either edge, 4-bit fields only) set the pin's pending bit. The bit becomes visible on the third rising clock edge after the pin changes, and it stays set until acknowledged.
- R5: Sense code 2 (active low) and code 3 (active high) make the pending bit follow the active level, with the same three-edge latency. An acknowledge has no lasting effect in these modes.
- R6: Any other sense code holds the pin's pending bit at 0.
- R7: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: When an acknowledge of a pin lands in the same cycle as a newly detected edge on that pin, the pin stays pending.
- R9: A 1 written to a mask-set position masks that pin. Positions written as 0 are unaffected.
- R10: A 1 written to a mask-clear position unmasks that pin. Positions written as 0 are unaffected.
- R11: A pin whose priority field is 0 raises no request, whatever its pending and mask state.
- R12: irq_pin[k] is high only while control bit 23 is 1 and pin k is pending, unmasked and has a nonzero priority.
- R13: irq_any is the OR over pins of (pending AND unmasked AND nonzero priority), independent of the control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPIN | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pin | output | NPIN | Per-pin requests, bit k for pin k |
| irq_any | output | 1 | OR of all ungated requests |

## Verification
The case where two functions meet in one cycle is a software acknowledge of a pin's pending bit that coincides with a fresh edge detected on that same pin. The bench provokes it directly. It raises a pin that is already pending and schedules a pending-register write of all zeros for exactly the clock edge on which the synchronised edge arrives. It then judges that the pin is still pending, and that a later acknowledge on its own clears it. The random phase also lets the two meet freely, and every such cycle is compared against a bench-side model built from the requirements.

// File: rtl/extpin_irq_ctrl.sv
module extpin_irq_ctrl #(
  parameter int NPIN     = 8,
  parameter int SENSE_W  = 4,
  parameter int FLAG_W   = 8,
  parameter int MODE_BIT = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NPIN-1:0] irq_pin,
  output logic            irq_any
);
  localparam int PRIO_W = 4;

  logic [31:0]     sense_q, prio_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;
  logic [NPIN-1:0] pend_q, pend_d, mask_q, mask_d, req_raw;
  logic            mode_q;
  logic [FLAG_W-1:0] pend_view;

  wire wr_sense = bus_we && bus_addr == 3'd0;
  wire wr_prio  = bus_we && bus_addr == 3'd1;
  wire wr_pend  = bus_we && bus_addr == 3'd2;
  wire wr_mset  = bus_we && bus_addr == 3'd3;
  wire wr_mclr  = bus_we && bus_addr == 3'd4;
  wire wr_mode  = bus_we && bus_addr == 3'd5;

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    wire [SENSE_W-1:0] code = sense_q[32-(k+1)*SENSE_W +: SENSE_W];
    wire [PRIO_W-1:0]  lvl  = prio_q[32-(k+1)*PRIO_W +: PRIO_W];
    wire rise = sync2_q[k] & ~prev_q[k];
    wire fall = ~sync2_q[k] & prev_q[k];
    wire keep = wr_pend ? (pend_q[k] & bus_wdata[FLAG_W-1-k]) : pend_q[k];

    always_comb begin
      case (int'(code))
        0:       pend_d[k] = fall | keep;
        1:       pend_d[k] = rise | keep;
        2:       pend_d[k] = ~sync2_q[k];
        3:       pend_d[k] = sync2_q[k];
        4:       pend_d[k] = rise | fall | keep;
        default: pend_d[k] = 1'b0;
      endcase
    end

    always_comb begin
      mask_d[k] = mask_q[k];
      if (wr_mset && bus_wdata[FLAG_W-1-k])      mask_d[k] = 1'b1;
      else if (wr_mclr && bus_wdata[FLAG_W-1-k]) mask_d[k] = 1'b0;
    end

    assign req_raw[k] = pend_q[k] & ~mask_q[k] & (lvl != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      sense_q <= '0;
      prio_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      pend_q  <= pend_d;
      mask_q  <= mask_d;
      if (wr_sense) sense_q <= bus_wdata;
      if (wr_prio)  prio_q  <= bus_wdata;
      if (wr_mode)  mode_q  <= bus_wdata[MODE_BIT];
    end
  end

  always_comb begin
    pend_view = '0;
    for (int k = 0; k < NPIN; k++) pend_view[FLAG_W-1-k] = pend_q[k];
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = sense_q;
      3'd1:    bus_rdata = prio_q;
      3'd2:    bus_rdata = 32'(pend_view);
      3'd5:    bus_rdata = 32'(mode_q) << MODE_BIT;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_pin = mode_q ? req_raw : '0;
  assign irq_any = |req_raw;
endmodule

// File: rtl/extpin_irq_ctrl_chk.sv
module extpin_irq_ctrl_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [NPIN-1:0] wr_bits,
  input logic [NPIN-1:0] irq_pin,
  input logic            irq_any,
  input logic [NPIN-1:0] pend_q,
  input logic [31:0]     prio_q,
  input logic            mode_q
);
  logic [NPIN-1:0] sel;
  always_comb for (int k = 0; k < NPIN; k++) sel[k] = wr_bits[NPIN-1-k];

  AST_PIN_IN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin != '0) |-> irq_any); // R13

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin != '0) |-> mode_q); // R12

  AST_ANY_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (pend_q != '0)); // R13

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd3) |=> ((irq_pin & $past(sel)) == '0)); // R9

  for (genvar k = 0; k < NPIN; k++) begin : g_prio
    AST_PRIO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pin[k] |-> (prio_q[32-(k+1)*4 +: 4] != 4'd0)); // R11
  end
endmodule

bind extpin_irq_ctrl extpin_irq_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wr_bits(bus_wdata[FLAG_W-1 -: NPIN]), .irq_pin(irq_pin), .irq_any(irq_any),
  .pend_q(pend_q), .prio_q(prio_q), .mode_q(mode_q)
);

// File: tb/extpin_irq_ctrl_test.sv
`timescale 1ns/1ps
module extpin_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_pin;
  logic        irq_any;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";

  logic [7:0]  m_s1, m_s2, m_prev, m_pend, m_mask;
  logic [31:0] m_sense, m_prio;
  logic        m_mode;

  always #2 clk = ~clk;

  extpin_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin(irq_pin), .irq_any(irq_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] nib(input logic [31:0] v, input int k);
    return v[31-4*k -: 4];
  endfunction

  function automatic logic [7:0] raw_req();
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = m_pend[k] & ~m_mask[k] & (nib(m_prio, k) != 4'd0);
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[7-k] = m_pend[k];
    case (a)
      3'd0: return m_sense;
      3'd1: return m_prio;
      3'd2: return {24'd0, v};
      3'd5: return {8'd0, m_mode, 23'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '1;
    m_sense = '0; m_prio = '0; m_mode = 1'b0;
  endtask

  task automatic model_step();
    logic [7:0] np;
    for (int k = 0; k < 8; k++) begin
      logic rise, fall, keep;
      rise = m_s2[k] & ~m_prev[k];
      fall = ~m_s2[k] & m_prev[k];
      keep = (bus_we && bus_addr == 3'd2) ? (m_pend[k] & bus_wdata[7-k]) : m_pend[k];
      case (nib(m_sense, k))
        4'd0: np[k] = fall | keep;
        4'd1: np[k] = rise | keep;
        4'd2: np[k] = ~m_s2[k];
        4'd3: np[k] = m_s2[k];
        4'd4: np[k] = rise | fall | keep;
        default: np[k] = 1'b0;
      endcase
    end
    m_pend = np;
    if (bus_we) begin
      case (bus_addr)
        3'd0: m_sense = bus_wdata;
        3'd1: m_prio = bus_wdata;
        3'd3: for (int k = 0; k < 8; k++) if (bus_wdata[7-k]) m_mask[k] = 1'b1;
        3'd4: for (int k = 0; k < 8; k++) if (bus_wdata[7-k]) m_mask[k] = 1'b0;
        3'd5: m_mode = bus_wdata[23];
        default: ;
      endcase
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
  endtask

  task automatic compare();
    logic [7:0] r;
    r = raw_req();
    check(cur_tag, 32'(irq_pin), 32'(m_mode ? r : 8'd0));
    check(cur_tag, 32'(irq_any), 32'(|r));
    check(cur_tag, bus_rdata, exp_rd(bus_addr));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic peek(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd5150));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset defaults
    check("R1", 32'(irq_pin), 32'd0);
    check("R1", 32'(irq_any), 32'd0);
    peek("R1", 3'd0, 32'd0);
    peek("R1", 3'd1, 32'd0);
    peek("R1", 3'd2, 32'd0);
    peek("R1", 3'd5, 32'd0);

    // R2 control and write-only registers
    cur_tag = "R2";
    wr(3'd5, 32'hFFFF_FFFF);
    peek("R2", 3'd5, 32'h0080_0000);
    peek("R2", 3'd3, 32'd0);
    peek("R2", 3'd4, 32'd0);
    peek("R2", 3'd6, 32'd0);
    peek("R2", 3'd7, 32'd0);
    wr(3'd1, 32'h1234_5678);
    peek("R2", 3'd1, 32'h1234_5678);

    // R3 / R4 pin 2 rising edge placement and latency
    cur_tag = "R3";
    wr(3'd0, 32'hFF1F_FFFF);
    wr(3'd1, 32'h00F0_0000);
    wr(3'd4, 32'h0000_0020);
    pin_in = 8'h04;
    tick(); tick();
    check("R4", 32'(irq_pin), 32'd0);
    tick();
    check("R4", 32'(irq_pin), 32'h04);
    peek("R3", 3'd2, 32'h20);
    cur_tag = "R4";
    pin_in = 8'h00;
    repeat (4) tick();
    check("R4", 32'(irq_pin), 32'h04);

    // R7 ones preserve, R8 ack coincides with new edge
    cur_tag = "R7";
    wr(3'd2, 32'h0000_00FF);
    peek("R7", 3'd2, 32'h20);
    cur_tag = "R8";
    pin_in = 8'h04;
    tick(); tick();
    bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'd0;
    tick();
    bus_we = 1'b0;
    peek("R8", 3'd2, 32'h20);
    cur_tag = "R7";
    wr(3'd2, 32'd0);
    peek("R7", 3'd2, 32'h00);

    // R12 mode gating, R13 combined output
    cur_tag = "R12";
    pin_in = 8'h00;
    wr(3'd0, 32'hFF3F_FFFF);
    pin_in = 8'h04;
    repeat (3) tick();
    wr(3'd5, 32'd0);
    check("R12", 32'(irq_pin), 32'd0);
    check("R13", 32'(irq_any), 32'd1);
    wr(3'd5, 32'h0080_0000);
    check("R12", 32'(irq_pin), 32'h04);

    // R5 level follows, ack has no lasting effect
    cur_tag = "R5";
    wr(3'd2, 32'd0);
    peek("R5", 3'd2, 32'h20);
    pin_in = 8'h00;
    repeat (3) tick();
    peek("R5", 3'd2, 32'h00);

    // R9 / R10 mask set and clear
    cur_tag = "R9";
    pin_in = 8'h04;
    repeat (3) tick();
    wr(3'd3, 32'h0000_00DF);
    check("R9", 32'(irq_pin), 32'h04);
    wr(3'd3, 32'h0000_0020);
    check("R9", 32'(irq_pin), 32'h00);
    cur_tag = "R10";
    wr(3'd4, 32'h0000_00DF);
    check("R10", 32'(irq_pin), 32'h00);
    wr(3'd4, 32'h0000_0020);
    check("R10", 32'(irq_pin), 32'h04);

    // R11 priority zero silences
    cur_tag = "R11";
    wr(3'd1, 32'h0000_0000);
    check("R11", 32'(irq_pin), 32'd0);
    check("R11", 32'(irq_any), 32'd0);

    // R6 invalid code
    cur_tag = "R6";
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFF5F_FFFF);
    pin_in = 8'h00;
    repeat (4) tick();
    pin_in = 8'h04;
    repeat (4) tick();
    peek("R6", 3'd2, 32'h00);

    // Random phase against model
    cur_tag = "R13";
    wr(3'd4, 32'hFF);
    for (int n = 0; n < 4000; n++) begin
      pin_in = pin_in ^ 8'($urandom & $urandom & $urandom);
      bus_addr = 3'($urandom % 8);
      bus_we = ($urandom % 4) == 0;
      if (bus_we) begin
        bus_addr = 3'($urandom % 6);
        d = $urandom;
        if (bus_addr == 3'd0)
          for (int k = 0; k < 8; k++) d[31-4*k -: 4] = 4'($urandom % 6);
        if (bus_addr == 3'd1)
          for (int k = 0; k < 8; k++) d[31-4*k -: 4] = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
        bus_wdata = d;
      end
      tick();
      bus_we = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule